// File: doc/BRIEF.md
# Bit-Slice ALU with Operand Select

This block is the combinational arithmetic and logic stage of a cascadable processor slice. Each cycle it picks an R operand and an S operand from four candidate words: the two register-file read ports, the direct data input and the Q register. It then applies one of eight operations, three arithmetic and five bitwise, and returns the result word F together with status flags.

A 3-bit source code picks the operand pair, and a 3-bit function code picks the operation. The carry-in takes part in the arithmetic operations only. The slice drives carry-out, overflow, zero and sign. It also drives active-low group generate and group propagate, so that several slices can be joined by an external lookahead unit. Register storage, writeback and the lookahead unit are not part of this block.

Top module: `bsalu_top`

## Requirements
- R1: The source code sets the (R,S) pair: 0=(A,Q), 1=(A,B), 2=(0,Q), 3=(0,B), 4=(0,A), 5=(D,A), 6=(D,Q), 7=(D,0). Here A and B are the two read ports, D is the direct data input and 0 is a forced zero.
- R2: The arithmetic function codes are 0, 1 and 2, and each result is taken modulo 2^WIDTH. Code 0 gives F = R+S+Cin. Code 1 gives F = S+(~R)+Cin, so S-R-1 when Cin is 0 and S-R when Cin is 1. Code 2 gives F = R+(~S)+Cin.
- R3: The logic function codes are 3=R|S, 4=R&S, 5=(~R)&S, 6=R^S and 7=~(R^S). For these codes F does not depend on the carry-in.
- R4: Carry-out is the carry out of the top bit of the adder, active high.
- R5: Overflow is high exactly when the carry into the top bit differs from the carry out of the top bit.
- R6: Zero is high exactly when every bit of F is low. Sign equals the top bit of F with no inversion.
- R7: The adder operands are X and Y, with generate gi = Xi&Yi and propagate pi = Xi|Yi. Propagate-out is the complement of the AND of all pi. Generate-out is the complement of G3 | P3&G2 | P3&P2&G1 | P3&P2&P1&G0, extended in the same way to WIDTH bits.
- R8: For the logic function codes the adder operands are R and S uninverted. Carry-out, overflow, generate and propagate therefore take the values that an add of R+S+Cin would give.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| portA | input | 4 | Register-file read port A data |
| portB | input | 4 | Register-file read port B data |
| dataIn | input | 4 | Direct data input |
| qIn | input | 4 | Q register value |
| srcCode | input | 3 | Operand pair select |
| funcCode | input | 3 | Operation select |
| carryIn | input | 1 | Carry into bit 0, active high |
| result | output | 4 | Result word F |
| genN | output | 1 | Group generate, active low |
| propN | output | 1 | Group propagate, active low |
| carryOut | output | 1 | Carry out of the top bit |
| overflow | output | 1 | Signed overflow |
| zero | output | 1 | Result-is-zero flag |
| sign | output | 1 | Top bit of the result |

## Verification
The bench goes after the two subtraction codes with both carry-in values. A design that swaps which operand is inverted, or that drops Cin, is off by one or negates the result. It also checks the forced-zero sources. A mux that passes stale data instead of zero corrupts codes 2, 3, 4 and 7. For the logic codes it covers both the independence from carry-in and the add-style flags, which a design that zeroes or inverts the operands there would miss. The lookahead outputs are checked against a full-width compare of the carry. A design with the wrong polarity or with a term dropped from the generate chain shows up when carries cross bit boundaries.

// File: rtl/bsalu_pkg.sv
package bsalu_pkg;

  typedef enum logic [1:0] {
    R_ZERO   = 2'd0,
    R_PORTA  = 2'd1,
    R_DIRECT = 2'd2
  } rSrc_e;

  typedef enum logic [1:0] {
    S_ZERO  = 2'd0,
    S_PORTA = 2'd1,
    S_PORTB = 2'd2,
    S_QREG  = 2'd3
  } sSrc_e;

  typedef enum logic [2:0] {
    OUT_SUM  = 3'd0,
    OUT_OR   = 3'd1,
    OUT_AND  = 3'd2,
    OUT_XOR  = 3'd3,
    OUT_XNOR = 3'd4
  } outSel_e;

  typedef struct packed {
    rSrc_e   rSrc;
    sSrc_e   sSrc;
    logic    addInvR;
    logic    addInvS;
    logic    logicInvR;
    outSel_e outSel;
  } aluCtrl_t;

endpackage

// File: rtl/bsalu_ctrl.sv
module bsalu_ctrl
  import bsalu_pkg::*;
(
  input  logic [2:0] srcCode,
  input  logic [2:0] funcCode,
  output aluCtrl_t   ctrl
);

  always_comb begin
    ctrl = '{rSrc: R_ZERO, sSrc: S_ZERO, addInvR: 1'b0, addInvS: 1'b0,
             logicInvR: 1'b0, outSel: OUT_SUM};
    unique case (srcCode)
      3'd0: begin ctrl.rSrc = R_PORTA;  ctrl.sSrc = S_QREG;  end
      3'd1: begin ctrl.rSrc = R_PORTA;  ctrl.sSrc = S_PORTB; end
      3'd2: begin ctrl.rSrc = R_ZERO;   ctrl.sSrc = S_QREG;  end
      3'd3: begin ctrl.rSrc = R_ZERO;   ctrl.sSrc = S_PORTB; end
      3'd4: begin ctrl.rSrc = R_ZERO;   ctrl.sSrc = S_PORTA; end
      3'd5: begin ctrl.rSrc = R_DIRECT; ctrl.sSrc = S_PORTA; end
      3'd6: begin ctrl.rSrc = R_DIRECT; ctrl.sSrc = S_QREG;  end
      default: begin ctrl.rSrc = R_DIRECT; ctrl.sSrc = S_ZERO; end
    endcase
    unique case (funcCode)
      3'd0: ctrl.outSel = OUT_SUM;
      3'd1: begin ctrl.outSel = OUT_SUM; ctrl.addInvR = 1'b1; end
      3'd2: begin ctrl.outSel = OUT_SUM; ctrl.addInvS = 1'b1; end
      3'd3: ctrl.outSel = OUT_OR;
      3'd4: ctrl.outSel = OUT_AND;
      3'd5: begin ctrl.outSel = OUT_AND; ctrl.logicInvR = 1'b1; end
      3'd6: ctrl.outSel = OUT_XOR;
      default: ctrl.outSel = OUT_XNOR;
    endcase
  end

endmodule

// File: rtl/bsalu_datapath.sv
module bsalu_datapath
  import bsalu_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  aluCtrl_t         ctrl,
  input  logic [WIDTH-1:0] portA,
  input  logic [WIDTH-1:0] portB,
  input  logic [WIDTH-1:0] dataIn,
  input  logic [WIDTH-1:0] qIn,
  input  logic             carryIn,
  output logic [WIDTH-1:0] result,
  output logic             genN,
  output logic             propN,
  output logic             carryOut,
  output logic             overflow,
  output logic             zero,
  output logic             sign
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] rOp, sOp, addX, addY, logR, sumBits, gBit, pBit;
  logic [WIDTH:0]   carry;
  logic [WIDTH:0]   grpGen;

  always_comb begin
    unique case (ctrl.rSrc)
      R_PORTA:  rOp = portA;
      R_DIRECT: rOp = dataIn;
      default:  rOp = '0;
    endcase
    unique case (ctrl.sSrc)
      S_PORTA: sOp = portA;
      S_PORTB: sOp = portB;
      S_QREG:  sOp = qIn;
      default: sOp = '0;
    endcase
  end

  assign addX = ctrl.addInvR ? ~rOp : rOp;
  assign addY = ctrl.addInvS ? ~sOp : sOp;
  assign logR = ctrl.logicInvR ? ~rOp : rOp;

  assign carry[0]  = carryIn;
  assign grpGen[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign gBit[i]      = addX[i] & addY[i];
    assign pBit[i]      = addX[i] | addY[i];
    assign carry[i+1]   = gBit[i] | (pBit[i] & carry[i]);
    assign sumBits[i]   = addX[i] ^ addY[i] ^ carry[i];
    assign grpGen[i+1]  = gBit[i] | (pBit[i] & grpGen[i]);
  end

  always_comb begin
    unique case (ctrl.outSel)
      OUT_OR:   result = logR | sOp;
      OUT_AND:  result = logR & sOp;
      OUT_XOR:  result = logR ^ sOp;
      OUT_XNOR: result = ~(logR ^ sOp);
      default:  result = sumBits;
    endcase
  end

  assign carryOut = carry[WIDTH];
  assign overflow = carry[WIDTH] ^ carry[MSB];
  assign genN     = ~grpGen[WIDTH];
  assign propN    = ~(&pBit);
  assign zero     = ~(|result);
  assign sign     = result[MSB];

endmodule

// File: rtl/bsalu_top.sv
module bsalu_top
  import bsalu_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] portA,
  input  logic [WIDTH-1:0] portB,
  input  logic [WIDTH-1:0] dataIn,
  input  logic [WIDTH-1:0] qIn,
  input  logic [2:0]       srcCode,
  input  logic [2:0]       funcCode,
  input  logic             carryIn,
  output logic [WIDTH-1:0] result,
  output logic             genN,
  output logic             propN,
  output logic             carryOut,
  output logic             overflow,
  output logic             zero,
  output logic             sign
);

  aluCtrl_t ctrl;

  bsalu_ctrl u_ctrl (
    .srcCode (srcCode),
    .funcCode(funcCode),
    .ctrl    (ctrl)
  );

  bsalu_datapath #(.WIDTH(WIDTH)) u_dp (
    .ctrl    (ctrl),
    .portA   (portA),
    .portB   (portB),
    .dataIn  (dataIn),
    .qIn     (qIn),
    .carryIn (carryIn),
    .result  (result),
    .genN    (genN),
    .propN   (propN),
    .carryOut(carryOut),
    .overflow(overflow),
    .zero    (zero),
    .sign    (sign)
  );

endmodule

// File: rtl/bsalu_checker.sv
module bsalu_checker #(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0] portA,
  input logic [WIDTH-1:0] portB,
  input logic [WIDTH-1:0] dataIn,
  input logic [2:0]       srcCode,
  input logic [2:0]       funcCode,
  input logic             carryIn,
  input logic [WIDTH-1:0] result,
  input logic             genN,
  input logic             propN,
  input logic             carryOut,
  input logic             overflow,
  input logic             zero,
  input logic             sign
);

  localparam int MSB = WIDTH - 1;

  always_comb begin
    // R4, R7: the ripple carry-out agrees with the lookahead pair
    a_r4_lookahead_carry: assert (carryOut == (~genN | (~propN & carryIn)))
      else $error("carry-out disagrees with generate/propagate");
    // R6
    a_r6_zero_flag: assert (zero == (result == '0))
      else $error("zero flag wrong");
    a_r6_sign_flag: assert (sign == result[MSB])
      else $error("sign flag wrong");
    if (srcCode == 3'd1 && funcCode == 3'd0) begin
      // R2
      a_r2_add_ab: assert ({carryOut, result} == ({1'b0, portA} + {1'b0, portB} + (WIDTH+1)'(carryIn)))
        else $error("A+B+Cin wrong");
      // R5
      a_r5_signed_overflow: assert (overflow ==
          ((portA[MSB] == portB[MSB]) && (result[MSB] != portA[MSB])))
        else $error("overflow wrong on add");
    end
    if (srcCode == 3'd1 && funcCode == 3'd6) begin
      a_r3_xor_ab: assert (result == (portA ^ portB))
        else $error("xor wrong");
    end
    if (srcCode == 3'd7 && funcCode == 3'd3) begin
      a_r1_pass_direct: assert (result == dataIn)
        else $error("D OR 0 wrong");
    end
  end

endmodule

bind bsalu_top bsalu_checker #(.WIDTH(WIDTH)) u_checker (
  .portA   (portA),
  .portB   (portB),
  .dataIn  (dataIn),
  .srcCode (srcCode),
  .funcCode(funcCode),
  .carryIn (carryIn),
  .result  (result),
  .genN    (genN),
  .propN   (propN),
  .carryOut(carryOut),
  .overflow(overflow),
  .zero    (zero),
  .sign    (sign)
);

// File: tb/bsalu_top_test.sv
module bsalu_top_test;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [3:0] portA, portB, dataIn, qIn, result;
  logic [2:0] srcCode, funcCode;
  logic carryIn, genN, propN, carryOut, overflow, zero, sign;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  bsalu_top uut (
    .portA(portA), .portB(portB), .dataIn(dataIn), .qIn(qIn),
    .srcCode(srcCode), .funcCode(funcCode), .carryIn(carryIn),
    .result(result), .genN(genN), .propN(propN), .carryOut(carryOut),
    .overflow(overflow), .zero(zero), .sign(sign)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (src=%0d func=%0d cin=%0b A=%h B=%h D=%h Q=%h)",
               tag, act, exp, srcCode, funcCode, carryIn, portA, portB, dataIn, qIn);
    end
  endtask

  task automatic apply(input logic [2:0] s, input logic [2:0] f, input logic c,
                       input logic [3:0] a, input logic [3:0] b,
                       input logic [3:0] d, input logic [3:0] q);
    @(negedge clk);
    srcCode = s; funcCode = f; carryIn = c;
    portA = a; portB = b; dataIn = d; qIn = q;
    #2;
  endtask

  // Reference built from the operand and function tables
  task automatic verify();
    logic [3:0] r, s, x, y, fexp;
    logic [4:0] sum;
    logic [3:0] c3;
    logic g, p, cexp, ovexp;
    string tagF;
    case (srcCode)
      3'd0: begin r = portA;  s = qIn;   end
      3'd1: begin r = portA;  s = portB; end
      3'd2: begin r = 4'd0;   s = qIn;   end
      3'd3: begin r = 4'd0;   s = portB; end
      3'd4: begin r = 4'd0;   s = portA; end
      3'd5: begin r = dataIn; s = portA; end
      3'd6: begin r = dataIn; s = qIn;   end
      default: begin r = dataIn; s = 4'd0; end
    endcase
    x = (funcCode == 3'd1) ? ~r : r;
    y = (funcCode == 3'd2) ? ~s : s;
    sum = {1'b0, x} + {1'b0, y} + 5'(carryIn);
    c3  = {1'b0, x[2:0]} + {1'b0, y[2:0]} + 4'(carryIn);
    cexp = sum[4];
    ovexp = c3[3] ^ sum[4];
    case (funcCode)
      3'd0: fexp = r + s + 4'(carryIn);
      3'd1: fexp = s - r - 4'd1 + 4'(carryIn);
      3'd2: fexp = r - s - 4'd1 + 4'(carryIn);
      3'd3: fexp = r | s;
      3'd4: fexp = r & s;
      3'd5: fexp = ~r & s;
      3'd6: fexp = r ^ s;
      default: fexp = ~(r ^ s);
    endcase
    // group propagate: every bit passes a carry; group generate: carry out with cin 0
    p = ((x | y) == 4'hF);
    g = ((({1'b0, x} + {1'b0, y}) >> 4) != 0);
    tagF = (funcCode < 3'd3) ? "R2 arithmetic result" : "R3 logic result";
    check(tagF, int'(result), int'(fexp));
    check((funcCode < 3'd3) ? "R4 carry-out" : "R8 carry-out", int'(carryOut), int'(cexp));
    check((funcCode < 3'd3) ? "R5 overflow" : "R8 overflow", int'(overflow), int'(ovexp));
    check("R6 zero", int'(zero), int'(fexp == 4'd0));
    check("R6 sign", int'(sign), int'(fexp[3]));
    check("R7 generate", int'(genN), int'(!g));
    check("R7 propagate", int'(propN), int'(!p));
  endtask

  initial begin
    logic [3:0] keep;
    // Directed: R1 source map with distinct words, OR with zero partner exposes each source
    apply(3'd7, 3'd3, 1'b0, 4'h1, 4'h2, 4'h4, 4'h8); check("R1 src7 D", int'(result), 4);
    apply(3'd4, 3'd3, 1'b0, 4'h1, 4'h2, 4'h4, 4'h8); check("R1 src4 A", int'(result), 1);
    apply(3'd3, 3'd3, 1'b0, 4'h1, 4'h2, 4'h4, 4'h8); check("R1 src3 B", int'(result), 2);
    apply(3'd2, 3'd3, 1'b0, 4'h1, 4'h2, 4'h4, 4'h8); check("R1 src2 Q", int'(result), 8);
    apply(3'd0, 3'd3, 1'b0, 4'h1, 4'h2, 4'h4, 4'h8); check("R1 src0 A|Q", int'(result), 9);
    apply(3'd6, 3'd3, 1'b0, 4'h1, 4'h2, 4'h4, 4'h8); check("R1 src6 D|Q", int'(result), 12);
    // R2 subtract boundaries: S-R with Cin=0 is S-R-1
    apply(3'd1, 3'd1, 1'b0, 4'h3, 4'h3, 4'h0, 4'h0); check("R2 S-R-1", int'(result), 15);
    check("R4 borrow", int'(carryOut), 0);
    apply(3'd1, 3'd1, 1'b1, 4'h3, 4'h3, 4'h0, 4'h0); check("R2 S-R", int'(result), 0);
    check("R6 zero on equal", int'(zero), 1);
    // R5: 7+1 overflows signed range
    apply(3'd1, 3'd0, 1'b0, 4'h7, 4'h1, 4'h0, 4'h0); check("R5 overflow 7+1", int'(overflow), 1);
    // R3: carry-in has no effect on logic result
    apply(3'd1, 3'd5, 1'b0, 4'h5, 4'hE, 4'h0, 4'h0); keep = result;
    apply(3'd1, 3'd5, 1'b1, 4'h5, 4'hE, 4'h0, 4'h0); check("R3 cin ignored", int'(result), int'(keep));
    // R8: logic function flags as add of R+S: F+F overflows
    apply(3'd1, 3'd6, 1'b0, 4'hF, 4'hF, 4'h0, 4'h0); check("R8 carry on xor", int'(carryOut), 1);
    check("R8 generate on xor", int'(genN), 0);
    // Sweep all codes, both carries, random operands
    for (int s = 0; s < 8; s++)
      for (int f = 0; f < 8; f++)
        for (int c = 0; c < 2; c++)
          for (int n = 0; n < 40; n++) begin
            apply(3'(s), 3'(f), 1'(c), 4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom));
            verify();
          end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule